// File: doc/BRIEF.md
# Multi-Width Accumulator Add/Subtract Unit

This unit is the add/subtract datapath behind a 16-bit microcontroller's 32-bit accumulator. It works on the accumulator's low and high halves. Each operation runs at byte, word or long-word width. An operation may take in the carry flag, as a carry or as a borrow, and one pair of byte operations works on packed decimal digits. Decode, operand fetch and timing are handled outside. The core is given the accumulator halves, a second operand, a 4-bit operation code, a destination select and the current carry flag.

When the strobe is high on a clock edge, the unit registers the following:
- the result,
- a set of byte-lane write enables that tell the writer which lanes of the destination to update,
- a flag that says whether the destination is the accumulator,
- fresh N, Z, V and C flags.

A two-state controller (ST_IDLE, ST_SHOW) marks each registered result as valid for exactly one cycle. It uses four transitions:
- ST_IDLE to ST_SHOW on a strobe.
- ST_SHOW to ST_SHOW on a back-to-back strobe.
- ST_SHOW to ST_IDLE when no strobe arrives.
- ST_IDLE to ST_IDLE while idle.

Top module: `aru_core`

## Requirements
- R1: While reset is low, and after reset until the first strobe, `res_vld`, `res`, `res_be`, `res_to_acc` and all four flags read zero.
- R2: Results and flags are registered on the edge where `in_vld` is high and appear on the next cycle with `res_vld` high for that one cycle. Without a strobe, `res_vld` is low and result, lanes and flags hold their values.
- R3: Codes 0 (add), 1 (sub), 2 (add with carry) and 3 (subtract with borrow) work on bytes. With `dst_acc`=1 they compute `acc_lo[7:0]` op `opnd[7:0]`, place the byte in `res[7:0]`, zero `res[31:8]`, and enable lanes `res_be`=4'b0011, so the upper byte of the low accumulator half is zero-extended.
- R4: With `dst_acc`=0, codes 0-3 and 8-11 compute `opnd` op `acc_lo`, with the operand first, at their width. Byte results set `res_be`=4'b0001 and word results set 4'b0011. Unwritten result bits are zero.
- R5: The carry forms (codes 2, 3, 10, 11) add `c_in` on addition and subtract it as a borrow on subtraction. All other binary codes ignore `c_in`.
- R6: Codes 4 and 5 compute `acc_hi[7:0]` + `acc_lo[7:0]` + C and `acc_hi[7:0]` - `acc_lo[7:0]` - C. They always target the accumulator, regardless of `dst_acc`, with `res_be`=4'b0011.
- R7: Codes 6 and 7 perform the same high-byte/low-byte add and subtract with carry on two packed decimal digits. The result is a valid decimal byte, C is the decimal carry out of (or borrow into) the upper digit, V is 0, and the destination is the accumulator with `res_be`=4'b0011.
- R8: Codes 8-11 are word add, sub, add-with-carry and subtract-with-borrow on `acc_lo` and `opnd[15:0]`. Codes 12 and 13 compute `acc_hi` +/- `acc_lo` with no carry and always target the accumulator. Word results are 16 bits with `res_be`=4'b0011.
- R9: Codes 14 and 15 add or subtract the 32-bit `opnd` to or from `{acc_hi,acc_lo}`, ignore `c_in`, always target the accumulator, and set `res_be`=4'b1111.
- R10: For binary codes, C is the unsigned carry out (add) or borrow (sub), and V is signed overflow, both at the selected width. In every code, N is the result's top bit and Z is set when the result is zero, both at the selected width.
- R11: `res_to_acc` is 1 when the result goes to the accumulator. For codes 0-3 and 8-11 this follows `dst_acc`; for all other codes it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| dst_acc | input | 1 | 1: accumulator destination, 0: register/memory destination |
| acc_lo | input | 16 | Accumulator low half |
| acc_hi | input | 16 | Accumulator high half |
| opnd | input | 32 | Second operand |
| c_in | input | 1 | Incoming carry flag |
| res_vld | output | 1 | Result valid, one cycle per strobe |
| res_to_acc | output | 1 | Result targets the accumulator |
| res | output | 32 | Result, unwritten bits zero |
| res_be | output | 4 | Byte-lane write enables |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry or borrow |

## Verification
Two functions can fall in the same cycle. One is capturing a new strobe while the previous result is still shown (the ST_SHOW to ST_SHOW transition). The other is applying carry-in together with width-dependent lane and zero-extension handling. The sweeps drive strobes on every cycle with different codes, widths and destinations, so every result is registered while its predecessor is on the outputs. Each cycle's lanes, flags and result are judged against an arithmetic model of that cycle's own inputs. A gap with no strobe then confirms that the last values hold.

// File: rtl/aru_pkg.sv
package aru_pkg;

    typedef enum logic [1:0] {
        WD_BYTE = 2'd0,
        WD_WORD = 2'd1,
        WD_LONG = 2'd2
    } width_e;

    typedef struct packed {
        width_e wd;
        logic   sub;
        logic   use_c;
        logic   self_op;
        logic   dec;
        logic   acc_only;
    } ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } state_e;

endpackage

// File: rtl/aru_decode.sv
module aru_decode
    import aru_pkg::*;
(
    input  logic [3:0] op,
    output ctrl_t      ctl
);

    // Pairs of codes share a class; bit 0 picks subtraction.
    always_comb begin
        ctl         = '0;
        ctl.sub     = op[0];
        unique case (op[3:1])
            3'b000: begin ctl.wd = WD_BYTE; end
            3'b001: begin ctl.wd = WD_BYTE; ctl.use_c = 1'b1; end
            3'b010: begin ctl.wd = WD_BYTE; ctl.use_c = 1'b1; ctl.self_op = 1'b1; end
            3'b011: begin ctl.wd = WD_BYTE; ctl.use_c = 1'b1; ctl.self_op = 1'b1; ctl.dec = 1'b1; end
            3'b100: begin ctl.wd = WD_WORD; end
            3'b101: begin ctl.wd = WD_WORD; ctl.use_c = 1'b1; end
            3'b110: begin ctl.wd = WD_WORD; ctl.self_op = 1'b1; end
            3'b111: begin ctl.wd = WD_LONG; end
            default: ;
        endcase
        ctl.acc_only = ctl.self_op | (ctl.wd == WD_LONG);
    end

endmodule

// File: rtl/aru_slice.sv
module aru_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v
);

    logic [W-1:0] bx;
    logic         cx;
    logic [W:0]   sum;

    // Subtraction as a + ~b + ~borrow; carry-out inverted gives borrow.
    always_comb begin
        bx  = sub ? ~b : b;
        cx  = sub ? ~cin : cin;
        sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        r   = sum[W-1:0];
        c   = sub ? ~sum[W] : sum[W];
        v   = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/aru_bcd.sv
module aru_bcd #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] r,
    output logic          c
);

    localparam int DIGITS = DW / 4;

    logic [DIGITS:0] cy;

    assign cy[0] = cin;

    // Digit-serial correction: each digit passes its carry/borrow on.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic       out_c;
        always_comb begin
            if (sub) raw = {1'b0, a[4*g +: 4]} - {1'b0, b[4*g +: 4]} - {4'b0, cy[g]};
            else     raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, cy[g]};
            out_c = sub ? raw[4] : (raw > 5'd9);
            if (out_c) r[4*g +: 4] = sub ? (raw[3:0] - 4'd6) : (raw[3:0] + 4'd6);
            else       r[4*g +: 4] = raw[3:0];
        end
        assign cy[g+1] = out_c;
    end

    assign c = cy[DIGITS];

endmodule

// File: rtl/aru_core.sv
module aru_core
    import aru_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [3:0]            op,
    input  logic                  dst_acc,
    input  logic [HALF_W-1:0]     acc_lo,
    input  logic [HALF_W-1:0]     acc_hi,
    input  logic [2*HALF_W-1:0]   opnd,
    input  logic                  c_in,
    output logic                  res_vld,
    output logic                  res_to_acc,
    output logic [2*HALF_W-1:0]   res,
    output logic [HALF_W/4-1:0]   res_be,
    output logic                  flag_n,
    output logic                  flag_z,
    output logic                  flag_v,
    output logic                  flag_c
);

    localparam int BYTE_W = HALF_W / 2;
    localparam int LONG_W = 2 * HALF_W;
    localparam int BE_W   = LONG_W / 8;
    localparam int HB_W   = HALF_W / 8;
    localparam logic [BE_W-1:0] BE_BYTE = {{(BE_W-1){1'b0}}, 1'b1};
    localparam logic [BE_W-1:0] BE_HALF = {{(BE_W-HB_W){1'b0}}, {HB_W{1'b1}}};
    localparam logic [BE_W-1:0] BE_ALL  = {BE_W{1'b1}};

    ctrl_t  ctl;
    state_e state, state_nxt;
    logic   to_acc, cin_eff;

    aru_decode u_dec (.op(op), .ctl(ctl));

    assign to_acc  = ctl.acc_only | dst_acc;
    assign cin_eff = ctl.use_c & c_in;

    // Operand steering per width; non-accumulator targets take the operand first.
    logic [BYTE_W-1:0] ba, bb, br, dr;
    logic [HALF_W-1:0] wa, wb, wr;
    logic [LONG_W-1:0] lr;
    logic              bc, bv, wc, wv, lc, lv, dc;

    always_comb begin
        if (ctl.self_op) begin
            ba = acc_hi[BYTE_W-1:0]; bb = acc_lo[BYTE_W-1:0];
            wa = acc_hi;             wb = acc_lo;
        end else if (to_acc) begin
            ba = acc_lo[BYTE_W-1:0]; bb = opnd[BYTE_W-1:0];
            wa = acc_lo;             wb = opnd[HALF_W-1:0];
        end else begin
            ba = opnd[BYTE_W-1:0];   bb = acc_lo[BYTE_W-1:0];
            wa = opnd[HALF_W-1:0];   wb = acc_lo;
        end
    end

    aru_slice #(.W(BYTE_W)) u_byte (.a(ba), .b(bb), .sub(ctl.sub), .cin(cin_eff),
                                    .r(br), .c(bc), .v(bv));
    aru_slice #(.W(HALF_W)) u_word (.a(wa), .b(wb), .sub(ctl.sub), .cin(cin_eff),
                                    .r(wr), .c(wc), .v(wv));
    aru_slice #(.W(LONG_W)) u_long (.a({acc_hi, acc_lo}), .b(opnd), .sub(ctl.sub),
                                    .cin(1'b0), .r(lr), .c(lc), .v(lv));
    aru_bcd   #(.DW(BYTE_W)) u_bcd (.a(acc_hi[BYTE_W-1:0]), .b(acc_lo[BYTE_W-1:0]),
                                    .sub(ctl.sub), .cin(c_in), .r(dr), .c(dc));

    // Result selection and flag formation at the chosen width.
    logic [LONG_W-1:0] nxt_res;
    logic [BE_W-1:0]   nxt_be;
    logic              nxt_n, nxt_z, nxt_v, nxt_c;
    logic [BYTE_W-1:0] r8;

    always_comb begin
        nxt_res = '0;
        nxt_be  = '0;
        r8      = ctl.dec ? dr : br;
        nxt_n   = 1'b0;
        nxt_z   = 1'b0;
        nxt_v   = 1'b0;
        nxt_c   = 1'b0;
        unique case (ctl.wd)
            WD_BYTE: begin
                nxt_res[BYTE_W-1:0] = r8;
                nxt_be = to_acc ? BE_HALF : BE_BYTE;
                nxt_n  = r8[BYTE_W-1];
                nxt_z  = (r8 == '0);
                nxt_v  = ctl.dec ? 1'b0 : bv;
                nxt_c  = ctl.dec ? dc : bc;
            end
            WD_WORD: begin
                nxt_res[HALF_W-1:0] = wr;
                nxt_be = BE_HALF;
                nxt_n  = wr[HALF_W-1];
                nxt_z  = (wr == '0);
                nxt_v  = wv;
                nxt_c  = wc;
            end
            WD_LONG: begin
                nxt_res = lr;
                nxt_be  = BE_ALL;
                nxt_n   = lr[LONG_W-1];
                nxt_z   = (lr == '0);
                nxt_v   = lv;
                nxt_c   = lc;
            end
            default: ;
        endcase
    end

    // Controller: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_vld ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nxt = in_vld ? ST_SHOW : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign res_vld = (state == ST_SHOW);

    // Output registers, loaded only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res        <= '0;
            res_be     <= '0;
            res_to_acc <= 1'b0;
            flag_n     <= 1'b0;
            flag_z     <= 1'b0;
            flag_v     <= 1'b0;
            flag_c     <= 1'b0;
        end else if (in_vld) begin
            res        <= nxt_res;
            res_be     <= nxt_be;
            res_to_acc <= to_acc;
            flag_n     <= nxt_n;
            flag_z     <= nxt_z;
            flag_v     <= nxt_v;
            flag_c     <= nxt_c;
        end
    end

    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld); // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld); // R2
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable({res, res_be, flag_n, flag_z, flag_v, flag_c})); // R2
    AST_DEC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctl.dec) |=> !flag_v); // R7
    AST_DEC_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctl.dec && acc_hi[3:0] <= 4'd9 && acc_hi[7:4] <= 4'd9
                 && acc_lo[3:0] <= 4'd9 && acc_lo[7:4] <= 4'd9)
        |=> (res[3:0] <= 4'd9 && res[7:4] <= 4'd9)); // R7
    AST_LONG_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctl.wd == WD_LONG) |=> (res_be == BE_ALL && res_to_acc)); // R9
    AST_BYTE_DST_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_to_acc && res_be == BE_BYTE) |-> (res[LONG_W-1:BYTE_W] == '0)); // R4
    AST_SELF_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctl.self_op) |=> res_to_acc); // R6

endmodule

// File: tb/tb_aru_core.sv
`timescale 1ns/1ps
module tb_aru_core;

    typedef struct packed {
        logic [31:0] res;
        logic [3:0]  be;
        logic        acc;
        logic        n;
        logic        z;
        logic        v;
        logic        c;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [3:0]  op = '0;
    logic        dst_acc = 1'b0;
    logic [15:0] acc_lo = '0, acc_hi = '0;
    logic [31:0] opnd = '0;
    logic        c_in = 1'b0;
    logic        res_vld, res_to_acc, flag_n, flag_z, flag_v, flag_c;
    logic [31:0] res;
    logic [3:0]  res_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aru_core dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .dst_acc(dst_acc),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .opnd(opnd), .c_in(c_in),
        .res_vld(res_vld), .res_to_acc(res_to_acc), .res(res), .res_be(res_be),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    function automatic obs_t actual();
        obs_t o;
        o.res = res; o.be = res_be; o.acc = res_to_acc;
        o.n = flag_n; o.z = flag_z; o.v = flag_v; o.c = flag_c;
        return o;
    endfunction

    function automatic logic [7:0] v8(int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h7E;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
            8: return 8'hFF;  9: return 8'h0F;  10: return 8'h10; 11: return 8'h55;
            12: return 8'hAA; 13: return 8'h3C; 14: return 8'h99; default: return 8'h40;
        endcase
    endfunction

    function automatic logic [31:0] v32(int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;  2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;  4: return 32'hFFFF_FFFF;  5: return 32'h0000_FFFF;
            6: return 32'h0001_0000;  7: return 32'h1234_8765;  8: return 32'hFEDC_7FFF;
            9: return 32'h8000_8001;  10: return 32'h7FFF_FFFE; default: return 32'h5A5A_8000;
        endcase
    endfunction

    function automatic logic [7:0] to_bcd(int x);
        return 8'((x / 10) * 16 + (x % 10));
    endfunction

    function automatic string tag(logic [3:0] o);
        if (o <= 3)       return "R3/R4/R5/R10/R11";
        else if (o <= 5)  return "R6/R5/R10/R11";
        else if (o <= 7)  return "R7/R11";
        else if (o <= 11) return "R8/R4/R5/R10/R11";
        else if (o <= 13) return "R8/R10/R11";
        else              return "R9/R10/R11";
    endfunction

    // Arithmetic model of the requirements.
    function automatic obs_t model(logic [3:0] o, logic d, logic [15:0] ah, logic [15:0] al,
                                   logic [31:0] od, logic ci);
        obs_t e;
        int w;
        bit sub, usec, selfop, dec, acconly;
        longint a, b, cie, full, mask, half, sa, sb, sr, r;
        e = '0;
        sub = o[0];
        w = (o <= 7) ? 8 : (o <= 13) ? 16 : 32;
        usec   = (o >= 2 && o <= 7) || o == 10 || o == 11;
        selfop = (o >= 4 && o <= 7) || o == 12 || o == 13;
        dec    = (o == 6) || (o == 7);
        acconly = selfop || (w == 32);
        e.acc = acconly | d;
        cie  = usec ? longint'(ci) : 0;
        mask = (64'sd1 <<< w) - 1;
        half = (mask + 1) / 2;
        if (dec) begin
            int da, db, vv;
            da = ah[7:4] * 10 + ah[3:0];
            db = al[7:4] * 10 + al[3:0];
            if (sub) begin
                vv = da - db - int'(cie);
                e.c = (vv < 0);
                if (vv < 0) vv += 100;
            end else begin
                vv = da + db + int'(cie);
                e.c = (vv >= 100);
                vv = vv % 100;
            end
            r = longint'(to_bcd(vv));
            e.v = 1'b0;
        end else begin
            if (selfop)      begin a = longint'(ah) & mask; b = longint'(al) & mask; end
            else if (w == 32) begin a = longint'({ah, al}); b = longint'(od); end
            else if (e.acc)  begin a = longint'(al) & mask; b = longint'(od) & mask; end
            else             begin a = longint'(od) & mask; b = longint'(al) & mask; end
            full = sub ? (a - b - cie) : (a + b + cie);
            e.c = sub ? (full < 0) : (full > mask);
            r = full & mask;
            sa = (a >= half) ? a - (mask + 1) : a;
            sb = (b >= half) ? b - (mask + 1) : b;
            sr = sub ? (sa - sb - cie) : (sa + sb + cie);
            e.v = (sr >= half) || (sr < -half);
        end
        e.res = 32'(r);
        e.n = ((r >>> (w - 1)) & 1) != 0;
        e.z = (r == 0);
        e.be = (w == 8) ? (e.acc ? 4'b0011 : 4'b0001) : (w == 16) ? 4'b0011 : 4'b1111;
        return e;
    endfunction

    task automatic check(string t, obs_t exp_o, logic exp_vld);
        obs_t act;
        act = actual();
        checks++;
        if (act !== exp_o || res_vld !== exp_vld) begin
            errors++;
            $display("FAIL %s: got vld=%b res=%h be=%b acc=%b nzvc=%b%b%b%b, expected vld=%b res=%h be=%b acc=%b nzvc=%b%b%b%b",
                     t, res_vld, act.res, act.be, act.acc, act.n, act.z, act.v, act.c,
                     exp_vld, exp_o.res, exp_o.be, exp_o.acc, exp_o.n, exp_o.z, exp_o.v, exp_o.c);
        end
    endtask

    // Called at a falling edge; drives one strobe and checks it a cycle later.
    task automatic run_op(logic [3:0] o, logic d, logic [15:0] ah, logic [15:0] al,
                          logic [31:0] od, logic ci);
        obs_t e;
        in_vld = 1'b1; op = o; dst_acc = d; acc_hi = ah; acc_lo = al; opnd = od; c_in = ci;
        e = model(o, d, ah, al, od, ci);
        @(negedge clk);
        check($sformatf("%s op=%0d", tag(o), o), e, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        obs_t last;
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0, 1'b0);

        // Byte binary forms, both destinations, both carry values.
        for (int o = 0; o < 4; o++)
            for (int d = 0; d < 2; d++)
                for (int ci = 0; ci < 2; ci++)
                    for (int i = 0; i < 16; i++)
                        for (int j = 0; j < 16; j++)
                            run_op(4'(o), 1'(d), {8'hC3, v8(j)}, {8'hA5, v8(i)},
                                   {24'h5A5A5A, v8(j)}, 1'(ci));

        // Byte self forms; dst_acc=0 must not matter.
        for (int o = 4; o < 6; o++)
            for (int ci = 0; ci < 2; ci++)
                for (int i = 0; i < 16; i++)
                    for (int j = 0; j < 16; j++)
                        run_op(4'(o), 1'((i + j) % 2), {8'h96, v8(i)}, {8'h69, v8(j)},
                               32'hFFFF_FFFF, 1'(ci));

        // Decimal forms over every valid digit pair.
        for (int o = 6; o < 8; o++)
            for (int ci = 0; ci < 2; ci++)
                for (int i = 0; i < 100; i++)
                    for (int j = 0; j < 100; j++)
                        run_op(4'(o), 1'(j % 2), {8'hC3, to_bcd(i)}, {8'h5A, to_bcd(j)},
                               32'h0000_0099, 1'(ci));

        // Word forms.
        for (int o = 8; o < 14; o++)
            for (int d = 0; d < 2; d++)
                for (int ci = 0; ci < 2; ci++)
                    for (int i = 0; i < 12; i++)
                        for (int j = 0; j < 12; j++)
                            run_op(4'(o), 1'(d), v32(i)[31:16] ^ v32(j)[15:0],
                                   v32(i)[15:0], v32(j), 1'(ci));

        // Long forms.
        for (int o = 14; o < 16; o++)
            for (int ci = 0; ci < 2; ci++)
                for (int i = 0; i < 12; i++)
                    for (int j = 0; j < 12; j++)
                        run_op(4'(o), 1'(j % 2), v32(i)[31:16], v32(i)[15:0], v32(j), 1'(ci));

        // No strobe: outputs hold while inputs move.
        last = model(4'd15, 1'b1, v32(11)[31:16], v32(11)[15:0], v32(11), 1'b1);
        in_vld = 1'b0; op = 4'd0; acc_lo = 16'h1111; opnd = 32'h2222_2222; c_in = 1'b1;
        @(negedge clk);
        check("R2 hold first idle cycle", last, 1'b0);
        op = 4'd6; acc_hi = 16'h0099;
        @(negedge clk);
        check("R2 hold second idle cycle", last, 1'b0);

        // Reset mid-stream clears everything.
        run_op(4'd0, 1'b1, 16'h0000, 16'h00FF, 32'h0000_0001, 1'b0);
        rst_n = 1'b0; in_vld = 1'b0;
        @(negedge clk);
        check("R1 reset after activity", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule